// File: doc/BRIEF.md
# Soft Reset and FIFO Flush Sequencer

This block holds the one control word through which software starts maintenance operations inside a USB controller. Software can request a whole-core soft reset, a reset of only the bus-side logic, a flush of one transmit FIFO chosen by number, a flush of the receive FIFO, or a restart of the frame counter. Each request raises a strobe toward the logic it acts on. The request bit also reads back as set while the operation runs, and it clears by itself when the operation ends.

The flushes run for a fixed number of clocks. The two reset kinds end when the reset logic returns a done pulse. If that pulse never comes, they end after a bounded timeout. The top bit of the word reports that the bus master is idle. Software polls this bit before it starts any further action. The reset logic and the FIFOs are not part of this block. It models only the handshake and the timing.

Top module: `softrst_flush_ctrl`

## Requirements
- R1: After reset, every request bit reads 0, the FIFO number field (bits 10:6) reads 0, all strobes are low, and bit 31 follows `master_idle_i`.
- R2: Writing 1 to bit 5 starts a transmit flush. Bit 5 and `txf_flush_o` are high for exactly 8 cycles, starting in the cycle after the write. The FIFO number in bits 10:6 of the same write is captured onto `txf_num_o`.
- R3: Writing 1 to bit 4 starts a receive flush. Bit 4 and `rxf_flush_o` are high for exactly 8 cycles, starting in the cycle after the write.
- R4: The captured transmit FIFO number holds during the flush and after it. It changes only when a new transmit flush is accepted or a core soft reset starts.
- R5: A flush request written while that same flush is still running is ignored. The running flush is not lengthened, and the FIFO number does not change.
- R6: Writing 1 to bit 1 starts a bus-side reset. `bus_rst_o` goes high in the cycle after the write and falls in the cycle after `bus_done_i` is sampled high. A flush that is already running is not affected.
- R7: Bit 31 reads 1 only while `master_idle_i` is high and neither reset kind is in progress.
- R8: A bus-side or core reset whose done input never arrives clears itself after 16 cycles high.
- R9: Writing 1 to bit 0 starts a core soft reset. In the cycle the reset starts, it cancels any running flush and any bus-side reset and clears the FIFO number to 0. It ends on `core_done_i` or on the timeout.
- R10: While a core soft reset is in progress, every write is ignored. A write that sets bit 0 ignores all the other bits it carries.
- R11: Writing 1 to bit 2 gives a single-cycle pulse on `frm_rst_o`, and bit 2 reads 1 for that cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Written control word |
| master_idle_i | input | 1 | Bus master reports idle |
| core_done_i | input | 1 | Core reset logic reports completion |
| bus_done_i | input | 1 | Bus-side reset logic reports completion |
| rd_data | output | 32 | Current control word with status |
| core_rst_o | output | 1 | Core soft reset strobe |
| bus_rst_o | output | 1 | Bus-side soft reset strobe |
| txf_flush_o | output | 1 | Transmit FIFO flush strobe |
| txf_num_o | output | 5 | Transmit FIFO number being flushed |
| rxf_flush_o | output | 1 | Receive FIFO flush strobe |
| frm_rst_o | output | 1 | Frame counter restart pulse |

## Verification
Each flush is first started alone. The bench checks the first cycle and the last cycle of the 8-cycle window, which catches an off-by-one count. A second transmit request is then written in the middle of a running flush, with a different FIFO number, to tell an ignored request apart from a restart or a number overwrite. Bus-side resets are run once with an early done pulse, once with no done pulse (the timeout path), and once beside a receive flush to show that they are independent. A core reset is issued on top of a running flush, carrying a receive request in the same word and followed by a write during the reset, to show the cancel, the number clearing and the write blocking.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int REG_W     = 32;
  localparam int CORE_BIT  = 0;
  localparam int BUS_BIT   = 1;
  localparam int FRM_BIT   = 2;
  localparam int RXF_BIT   = 4;
  localparam int TXF_BIT   = 5;
  localparam int TXN_LSB   = 6;
  localparam int IDLE_BIT  = 31;

  typedef enum logic {
    UNIT_IDLE = 1'b0,
    UNIT_BUSY = 1'b1
  } unit_st_e;
endpackage

// File: rtl/srf_req_unit.sv
module srf_req_unit
  import srf_pkg::*;
#(
  parameter int LIMIT    = 8,
  parameter int USE_DONE = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  input  logic done_i,
  output logic busy_o
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LIMIT - 1);

  unit_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             st_en, cnt_en;
  logic             done_hit, at_last;

  assign done_hit = done_i & (USE_DONE != 0);
  assign at_last  = (cnt_q == LAST_CNT);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    st_en  = 1'b0;
    cnt_en = 1'b0;
    if (abort_i) begin
      st_d   = UNIT_IDLE;
      st_en  = 1'b1;
    end else if (st_q == UNIT_BUSY) begin
      if (done_hit || at_last) begin
        st_d  = UNIT_IDLE;
        st_en = 1'b1;
      end else begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
    end else if (start_i) begin
      st_d   = UNIT_BUSY;
      st_en  = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= UNIT_IDLE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (st_q == UNIT_BUSY);
endmodule

// File: rtl/srf_decode.sv
module srf_decode
  import srf_pkg::*;
(
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             core_busy_i,
  input  logic             tx_busy_i,
  input  logic             rx_busy_i,
  output logic             core_start_o,
  output logic             bus_start_o,
  output logic             tx_start_o,
  output logic             rx_start_o,
  output logic             frm_req_o
);
  logic wr_ok, plain_ok;

  always_comb begin
    wr_ok        = wr_en & ~core_busy_i;
    core_start_o = wr_ok & wr_data[CORE_BIT];
    plain_ok     = wr_ok & ~wr_data[CORE_BIT];
    bus_start_o  = plain_ok & wr_data[BUS_BIT];
    tx_start_o   = plain_ok & wr_data[TXF_BIT] & ~tx_busy_i;
    rx_start_o   = plain_ok & wr_data[RXF_BIT] & ~rx_busy_i;
    frm_req_o    = plain_ok & wr_data[FRM_BIT];
  end
endmodule

// File: rtl/srf_side_regs.sv
module srf_side_regs #(
  parameter int TXN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_start_i,
  input  logic             tx_start_i,
  input  logic [TXN_W-1:0] txn_i,
  input  logic             frm_req_i,
  output logic [TXN_W-1:0] txn_o,
  output logic             frm_o
);
  logic [TXN_W-1:0] txn_q, txn_d;
  logic             txn_en;
  logic             frm_q;

  always_comb begin
    txn_d  = txn_q;
    txn_en = 1'b0;
    if (core_start_i) begin
      txn_d  = '0;
      txn_en = 1'b1;
    end else if (tx_start_i) begin
      txn_d  = txn_i;
      txn_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txn_q <= '0;
    end else if (txn_en) begin
      txn_q <= txn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q <= 1'b0;
    end else begin
      frm_q <= frm_req_i;
    end
  end

  assign txn_o = txn_q;
  assign frm_o = frm_q;
endmodule

// File: rtl/softrst_flush_ctrl.sv
module softrst_flush_ctrl
  import srf_pkg::*;
#(
  parameter int FLUSH_LEN   = 8,
  parameter int RST_TIMEOUT = 16,
  parameter int TXN_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             master_idle_i,
  input  logic             core_done_i,
  input  logic             bus_done_i,
  output logic [31:0]      rd_data,
  output logic             core_rst_o,
  output logic             bus_rst_o,
  output logic             txf_flush_o,
  output logic [TXN_W-1:0] txf_num_o,
  output logic             rxf_flush_o,
  output logic             frm_rst_o
);
  localparam int N_UNITS = 4;
  localparam int U_CORE  = 0;
  localparam int U_BUS   = 1;
  localparam int U_TX    = 2;
  localparam int U_RX    = 3;

  logic [N_UNITS-1:0] start_v, abort_v, done_v, busy_v;
  logic               core_start, bus_start, tx_start, rx_start, frm_req;
  logic [TXN_W-1:0]   txn_q;
  logic               frm_q;

  srf_decode u_dec (
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .core_busy_i (busy_v[U_CORE]),
    .tx_busy_i   (busy_v[U_TX]),
    .rx_busy_i   (busy_v[U_RX]),
    .core_start_o(core_start),
    .bus_start_o (bus_start),
    .tx_start_o  (tx_start),
    .rx_start_o  (rx_start),
    .frm_req_o   (frm_req)
  );

  assign start_v = {rx_start, tx_start, bus_start, core_start};
  assign abort_v = {core_start, core_start, core_start, 1'b0};
  assign done_v  = {1'b0, 1'b0, bus_done_i, core_done_i};

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    localparam bit IS_RST = (g == U_CORE) || (g == U_BUS);
    srf_req_unit #(
      .LIMIT    (IS_RST ? RST_TIMEOUT : FLUSH_LEN),
      .USE_DONE (IS_RST ? 1 : 0)
    ) u_unit (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_v[g]),
      .abort_i(abort_v[g]),
      .done_i (done_v[g]),
      .busy_o (busy_v[g])
    );
  end

  srf_side_regs #(.TXN_W(TXN_W)) u_side (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_start_i(core_start),
    .tx_start_i  (tx_start),
    .txn_i       (wr_data[TXN_LSB +: TXN_W]),
    .frm_req_i   (frm_req),
    .txn_o       (txn_q),
    .frm_o       (frm_q)
  );

  always_comb begin
    rd_data                      = '0;
    rd_data[CORE_BIT]            = busy_v[U_CORE];
    rd_data[BUS_BIT]             = busy_v[U_BUS];
    rd_data[FRM_BIT]             = frm_q;
    rd_data[RXF_BIT]             = busy_v[U_RX];
    rd_data[TXF_BIT]             = busy_v[U_TX];
    rd_data[TXN_LSB +: TXN_W]    = txn_q;
    rd_data[IDLE_BIT]            = master_idle_i & ~busy_v[U_CORE] & ~busy_v[U_BUS];
  end

  assign core_rst_o  = busy_v[U_CORE];
  assign bus_rst_o   = busy_v[U_BUS];
  assign txf_flush_o = busy_v[U_TX];
  assign rxf_flush_o = busy_v[U_RX];
  assign txf_num_o   = txn_q;
  assign frm_rst_o   = frm_q;
endmodule

// File: rtl/srf_chk.sv
module srf_chk #(
  parameter int FLUSH_LEN   = 8,
  parameter int RST_TIMEOUT = 16,
  parameter int TXN_W       = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [31:0]      rd_data,
  input logic             core_rst_o,
  input logic             bus_rst_o,
  input logic             txf_flush_o,
  input logic [TXN_W-1:0] txf_num_o,
  input logic             rxf_flush_o
);
  logic [15:0] tx_run, rx_run, bus_run, core_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_run   <= '0;
      rx_run   <= '0;
      bus_run  <= '0;
      core_run <= '0;
    end else begin
      tx_run   <= txf_flush_o ? tx_run + 1'b1 : '0;
      rx_run   <= rxf_flush_o ? rx_run + 1'b1 : '0;
      bus_run  <= bus_rst_o   ? bus_run + 1'b1 : '0;
      core_run <= core_rst_o  ? core_run + 1'b1 : '0;
    end
  end

  // R2
  tx_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txf_flush_o |-> (tx_run < 16'(FLUSH_LEN)));
  // R2
  tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(txf_flush_o) && !core_rst_o) |-> ($past(tx_run) == 16'(FLUSH_LEN - 1)));
  // R3
  rx_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_flush_o |-> (rx_run < 16'(FLUSH_LEN)));
  // R8
  bus_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_o |-> (bus_run < 16'(RST_TIMEOUT)));
  // R8
  core_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> (core_run < 16'(RST_TIMEOUT)));
  // R4
  txnum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txf_flush_o && $past(txf_flush_o)) |-> $stable(txf_num_o));
  // R9
  core_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> (!txf_flush_o && !rxf_flush_o && !bus_rst_o));
  // R7
  idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_o || core_rst_o) |-> !rd_data[31]);
  // R10
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxf_flush_o) |-> ($past(wr_en) && !$past(core_rst_o)));
endmodule

bind softrst_flush_ctrl srf_chk #(
  .FLUSH_LEN  (FLUSH_LEN),
  .RST_TIMEOUT(RST_TIMEOUT),
  .TXN_W      (TXN_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_data    (rd_data),
  .core_rst_o (core_rst_o),
  .bus_rst_o  (bus_rst_o),
  .txf_flush_o(txf_flush_o),
  .txf_num_o  (txf_num_o),
  .rxf_flush_o(rxf_flush_o)
);

// File: tb/softrst_flush_ctrl_bench.sv
`timescale 1ns/1ps
module softrst_flush_ctrl_bench;
  localparam logic [31:0] M_CORE = 32'h1;
  localparam logic [31:0] M_BUS  = 32'h2;
  localparam logic [31:0] M_FRM  = 32'h4;
  localparam logic [31:0] M_RX   = 32'h10;
  localparam logic [31:0] M_TX   = 32'h20;
  localparam logic [31:0] M_NUM  = 32'h7C0;
  localparam logic [31:0] M_IDLE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        master_idle_i = 1'b1;
  logic        core_done_i = 1'b0;
  logic        bus_done_i = 1'b0;
  logic [31:0] rd_data;
  logic        core_rst_o, bus_rst_o, txf_flush_o, rxf_flush_o, frm_rst_o;
  logic [4:0]  txf_num_o;

  softrst_flush_ctrl u_softrst_flush_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .master_idle_i(master_idle_i), .core_done_i(core_done_i),
    .bus_done_i(bus_done_i), .rd_data(rd_data), .core_rst_o(core_rst_o),
    .bus_rst_o(bus_rst_o), .txf_flush_o(txf_flush_o), .txf_num_o(txf_num_o),
    .rxf_flush_o(rxf_flush_o), .frm_rst_o(frm_rst_o)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    logic [31:0] mask;
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  task automatic expect_at(input int at, input logic [31:0] mask,
                           input logic [31:0] val, input string tag);
    exp_t e;
    e.at = at; e.mask = mask; e.val = val; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic expect_span(input int from, input int to, input logic [31:0] mask,
                             input logic [31:0] val, input string tag);
    for (int i = from; i <= to; i++) expect_at(i, mask, val, tag);
  endtask

  // monitor: ports rebuilt into the word layout and compared with rd_data too
  always @(negedge clk) begin
    logic [31:0] obs;
    obs = rd_data;
    obs[0] = core_rst_o; obs[1] = bus_rst_o; obs[2] = frm_rst_o;
    obs[4] = rxf_flush_o; obs[5] = txf_flush_o; obs[10:6] = txf_num_o;
    while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (e.at < cyc) begin
        n_fail++;
        $display("FAIL %s: missed cycle %0d (now %0d) actual %h expected %h",
                 e.tag, e.at, cyc, rd_data & e.mask, e.val);
      end else if (((rd_data & e.mask) !== e.val) || ((obs & e.mask) !== e.val)) begin
        n_fail++;
        $display("FAIL %s: cycle %0d actual word %h ports %h expected %h",
                 e.tag, cyc, rd_data & e.mask, obs & e.mask, e.val);
      end
    end
  end

  task automatic go(input int t);
    while (cyc < t) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr_now(input logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic pulse_bus_done(input int t);
    go(t);
    bus_done_i = 1'b1;
    @(posedge clk); #1;
    bus_done_i = 1'b0;
  endtask

  task automatic drain;
    while (exp_q.size() > 0) begin
      @(posedge clk);
      #1;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    expect_at(cyc, 32'hFFFF_FFFF, 32'h8000_0000, "R1 reset word");
    drain();

    // R2 transmit flush, FIFO 5, exactly 8 cycles
    c = cyc;
    wr_now(M_TX | (32'd5 << 6));
    expect_span(c + 1, c + 8, M_TX | M_NUM, M_TX | (32'd5 << 6), "R2 tx busy");
    expect_at(c + 9, M_TX | M_NUM, (32'd5 << 6), "R2 tx clear, R4 num held");
    drain();

    // R3 receive flush
    c = cyc;
    wr_now(M_RX);
    expect_span(c + 1, c + 8, M_RX, M_RX, "R3 rx busy");
    expect_at(c + 9, M_RX, 32'h0, "R3 rx clear");
    drain();

    // R5 second tx request mid-flush ignored
    c = cyc;
    wr_now(M_TX | (32'd3 << 6));
    expect_span(c + 1, c + 8, M_TX | M_NUM, M_TX | (32'd3 << 6), "R5 tx run kept");
    expect_at(c + 9, M_TX | M_NUM, (32'd3 << 6), "R5 no extension");
    go(c + 3);
    wr_now(M_TX | (32'd9 << 6));
    drain();

    // R6 bus reset ended by done, R7 idle flag low meanwhile
    c = cyc;
    wr_now(M_BUS);
    expect_span(c + 1, c + 3, M_BUS | M_IDLE, M_BUS, "R6 R7 bus busy");
    expect_at(c + 4, M_BUS | M_IDLE, M_IDLE, "R6 R7 bus done");
    pulse_bus_done(c + 3);
    drain();

    // R6 bus reset leaves a receive flush running
    c = cyc;
    wr_now(M_BUS | M_RX);
    expect_at(c + 2, M_BUS | M_RX, M_BUS | M_RX, "R6 both busy");
    expect_span(c + 3, c + 8, M_BUS | M_RX, M_RX, "R6 rx survives");
    expect_at(c + 9, M_BUS | M_RX, 32'h0, "R6 rx ends");
    pulse_bus_done(c + 2);
    drain();

    // R8 bus reset timeout
    c = cyc;
    wr_now(M_BUS);
    expect_at(c + 1, M_BUS, M_BUS, "R8 start");
    expect_at(c + 16, M_BUS, M_BUS, "R8 last");
    expect_at(c + 17, M_BUS, 32'h0, "R8 timeout");
    drain();

    // R9 R10 core reset over running tx flush; carried rx bit and later write ignored
    c = cyc;
    wr_now(M_TX | (32'd7 << 6));
    expect_at(c + 2, M_TX | M_NUM, M_TX | (32'd7 << 6), "R9 tx before core");
    expect_at(c + 3, M_CORE | M_TX | M_RX | M_NUM | M_IDLE, M_CORE,
              "R9 R10 core cancels tx, num 0, rx bit ignored");
    expect_at(c + 6, M_RX | M_BUS, 32'h0, "R10 write during core ignored");
    expect_at(c + 18, M_CORE, M_CORE, "R9 core last");
    expect_at(c + 19, M_CORE | M_IDLE, M_IDLE, "R9 R8 core timeout");
    go(c + 2);
    wr_now(M_CORE | M_RX);
    go(c + 5);
    wr_now(M_RX | M_BUS);
    drain();

    // R9 core reset ended by done
    c = cyc;
    wr_now(M_CORE);
    expect_at(c + 4, M_CORE, M_CORE, "R9 core busy");
    expect_at(c + 5, M_CORE, 32'h0, "R9 core done");
    go(c + 4);
    core_done_i = 1'b1;
    @(posedge clk); #1;
    core_done_i = 1'b0;
    drain();

    // R11 frame counter pulse
    c = cyc;
    wr_now(M_FRM);
    expect_at(c + 1, M_FRM, M_FRM, "R11 pulse");
    expect_at(c + 2, M_FRM, 32'h0, "R11 pulse ends");
    drain();

    // R7 master busy drops the flag
    master_idle_i = 1'b0;
    expect_at(cyc, M_IDLE, 32'h0, "R7 master busy");
    drain();
    master_idle_i = 1'b1;
    expect_at(cyc, M_IDLE, M_IDLE, "R7 master idle");
    drain();

    finish_run();
  end
endmodule